// File: doc/BRIEF.md
# Multi-Drop Serial Receiver with Address Filtering

This block is an asynchronous serial receiver for buses with many drops. It takes frames with either eight or nine data bits, sent least significant bit first between a low start bit and a high stop bit. The line is timed by a clock-enable tick that runs at sixteen times the bit rate. A receive-enable control gates all reception. A nine-bit control picks the frame length. An address-filter control lets a drop ignore traffic that is not addressed to it.

When the address filter is on and nine-bit frames are selected, the ninth bit marks the frame type. A frame with the ninth bit at 1 is an address and reaches the output. A frame with the ninth bit at 0 is data and is discarded once its stop bit has been sampled. The host inspects each address. When it recognises its own, it turns the filter off and from then on receives every frame, data and address alike. With the filter off, or with eight-bit frames, every frame is delivered, and in nine-bit mode the ninth bit is passed out unchanged so that it can serve as a parity bit.

Received frames leave on a valid/ready stream. `rx_valid` rises when a frame is delivered and stays high, with data, ninth bit and framing flag held steady, until a cycle in which `rx_ready` is also high. The clock edge at the end of that cycle empties the output. There is no queue behind the output. If a new frame has to be delivered while the output is still full, that frame is lost, an overrun error is latched and reception stops. Reception resumes only after receive-enable has been taken low.

Top module: `mp_uart_rx`

## Requirements
- R1: With `nine_bit_en`=0, a frame consists of a low start bit, eight data bits sent least significant bit first, and a stop bit. It is delivered with `rx_data` equal to the eight data bits and `rx_bit9`=0.
- R2: With `nine_bit_en`=1, a frame carries nine data bits. The first eight appear on `rx_data` and the ninth on `rx_bit9`.
- R3: With `nine_bit_en`=1 and `addr_filt_en`=1, a frame whose ninth bit is 1 is delivered and raises `rx_valid`.
- R4: With `nine_bit_en`=1 and `addr_filt_en`=1, a frame whose ninth bit is 0 is dropped. `rx_valid` stays 0, `rx_data` keeps its previous value, and the next frame replaces the dropped one in the shift register.
- R5: With `nine_bit_en`=0, `addr_filt_en` has no effect and every frame is delivered.
- R6: With `addr_filt_en`=0, every frame is delivered whatever its ninth bit is, and the ninth bit is passed through. The filter may be cleared between frames, and every later frame is then delivered.
- R7: `rx_valid` stays high and `rx_data`/`rx_bit9` stay stable until a cycle with `rx_ready`=1. `rx_valid` is 0 in the cycle after that handshake.
- R8: A delivered frame whose stop bit is sampled low sets `frame_err`=1 together with that frame. A delivered frame with a high stop bit sets `frame_err`=0. A dropped frame leaves `frame_err` unchanged.
- R9: If a frame is due for delivery while `rx_valid`=1 and `rx_ready`=0, that frame is lost and `overrun_err` is set. The output keeps the old frame, and no further frame is received until `rx_en` goes low.
- R10: While `rx_en`=0, no frame is received, and `frame_err` and `overrun_err` are cleared.
- R11: A frame starts only on a high-to-low transition of the line. The start bit must still be low at its middle (8 ticks later). A shorter low pulse is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial line, idle high |
| os_tick | input | 1 | Oversampling enable, 16 per bit time |
| rx_en | input | 1 | Receive enable; low clears errors |
| nine_bit_en | input | 1 | 1: nine data bits per frame |
| addr_filt_en | input | 1 | 1 (with nine-bit mode): drop frames whose ninth bit is 0 |
| rx_ready | input | 1 | Consumer accepts the output this cycle |
| rx_valid | output | 1 | Output holds an unread frame |
| rx_data | output | 8 | Received byte |
| rx_bit9 | output | 1 | Received ninth bit (0 in eight-bit mode) |
| frame_err | output | 1 | Stop bit of the delivered frame was low |
| overrun_err | output | 1 | A frame was lost to a full output; reception halted |

## Verification
The hardest state to reach from the ports is a frame that must be dropped even though it is complete. Its absence cannot be seen directly, so the bench first delivers and reads a known byte. It then sends the frame that should be discarded and checks that `rx_valid` stays low and `rx_data` still holds the older byte. Next it sends an address frame straight after a discarded data frame, which shows that the address replaces the discarded data in the shift register. Overrun is reached by withholding `rx_ready` across two deliverable frames and a third that arrives while reception is halted.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/mpr_sync.sv
module mpr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/mpr_bit_engine.sv
module mpr_bit_engine
  import mpr_pkg::*;
#(
  parameter int OSR  = 16,
  parameter int MAXB = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            line,
  input  logic            halt,
  input  logic            nine,
  output logic            done,
  output logic [MAXB-1:0] bits,
  output logic            stop_ok
);
  localparam int CW   = $clog2(OSR);
  localparam int IW   = $clog2(MAXB + 1);
  localparam int HALF = OSR / 2;

  rx_state_e         state;
  logic [CW-1:0]     cnt;
  logic [IW-1:0]     idx;
  logic [IW-1:0]     last_idx;
  logic              prev_line;

  // Index of the final data bit for the selected frame length
  assign last_idx = nine ? IW'(MAXB - 1) : IW'(MAXB - 2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      cnt       <= '0;
      idx       <= '0;
      prev_line <= 1'b1;
      bits      <= '0;
      stop_ok   <= 1'b1;
      done      <= 1'b0;
    end else if (halt) begin
      state     <= RX_IDLE;
      cnt       <= '0;
      done      <= 1'b0;
      prev_line <= line;
    end else begin
      done <= 1'b0;
      if (tick) begin
        prev_line <= line;
        unique case (state)
          RX_IDLE: begin
            if (prev_line && !line) begin
              state <= RX_START;
              cnt   <= '0;
            end
          end
          RX_START: begin
            if (cnt == CW'(HALF - 1)) begin
              cnt <= '0;
              if (!line) begin
                state <= RX_DATA;
                idx   <= '0;
                bits  <= '0;
              end else begin
                state <= RX_IDLE;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_DATA: begin
            if (cnt == CW'(OSR - 1)) begin
              cnt       <= '0;
              bits[idx] <= line;
              if (idx == last_idx) state <= RX_STOP;
              else                 idx   <= idx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          RX_STOP: begin
            if (cnt == CW'(OSR - 1)) begin
              cnt     <= '0;
              stop_ok <= line;
              done    <= 1'b1;
              state   <= RX_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mpr_frame_gate.sv
module mpr_frame_gate #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done,
  input  logic [DW:0]   bits,
  input  logic          stop_ok,
  input  logic          nine,
  input  logic          addr_filt,
  input  logic          rx_en,
  input  logic          ready,
  output logic          valid,
  output logic [DW-1:0] data,
  output logic          bit9,
  output logic          ferr,
  output logic          oerr
);
  logic filtering;
  logic deliver;
  logic accept;

  assign filtering = nine && addr_filt;
  assign deliver   = done && rx_en && (!filtering || bits[DW]);
  assign accept    = valid && ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
      bit9  <= 1'b0;
      ferr  <= 1'b0;
      oerr  <= 1'b0;
    end else begin
      if (!rx_en) begin
        ferr <= 1'b0;
        oerr <= 1'b0;
      end
      if (accept) valid <= 1'b0;
      if (deliver) begin
        if (valid && !ready) begin
          oerr <= 1'b1;
        end else begin
          valid <= 1'b1;
          data  <= bits[DW-1:0];
          bit9  <= nine & bits[DW];
          ferr  <= !stop_ok;
        end
      end
    end
  end
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx #(
  parameter int DW          = 8,
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_line,
  input  logic          os_tick,
  input  logic          rx_en,
  input  logic          nine_bit_en,
  input  logic          addr_filt_en,
  input  logic          rx_ready,
  output logic          rx_valid,
  output logic [DW-1:0] rx_data,
  output logic          rx_bit9,
  output logic          frame_err,
  output logic          overrun_err
);
  localparam int MAXB = DW + 1;

  logic            line_s;
  logic            halt;
  logic            done;
  logic [MAXB-1:0] bits;
  logic            stop_ok;

  assign halt = !rx_en || overrun_err;

  mpr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rx_line),
    .dout (line_s)
  );

  mpr_bit_engine #(.OSR(OSR), .MAXB(MAXB)) u_eng (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (os_tick),
    .line   (line_s),
    .halt   (halt),
    .nine   (nine_bit_en),
    .done   (done),
    .bits   (bits),
    .stop_ok(stop_ok)
  );

  mpr_frame_gate #(.DW(DW)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (done),
    .bits     (bits),
    .stop_ok  (stop_ok),
    .nine     (nine_bit_en),
    .addr_filt(addr_filt_en),
    .rx_en    (rx_en),
    .ready    (rx_ready),
    .valid    (rx_valid),
    .data     (rx_data),
    .bit9     (rx_bit9),
    .ferr     (frame_err),
    .oerr     (overrun_err)
  );
endmodule

// File: rtl/mp_uart_rx_chk.sv
module mp_uart_rx_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_en,
  input logic          nine_bit_en,
  input logic          addr_filt_en,
  input logic          rx_ready,
  input logic          rx_valid,
  input logic [DW-1:0] rx_data,
  input logic          rx_bit9,
  input logic          frame_err,
  input logic          overrun_err
);
  p_valid_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid);

  p_data_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> $stable(rx_data) && $stable(rx_bit9));

  p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_err && rx_en |=> overrun_err);

  p_disable_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !overrun_err && !frame_err);

  p_addr_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) && $past(nine_bit_en && addr_filt_en) |-> rx_bit9);

  p_eight_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_valid) && !$past(nine_bit_en) |-> !rx_bit9);
endmodule

bind mp_uart_rx mp_uart_rx_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_en       (rx_en),
  .nine_bit_en (nine_bit_en),
  .addr_filt_en(addr_filt_en),
  .rx_ready    (rx_ready),
  .rx_valid    (rx_valid),
  .rx_data     (rx_data),
  .rx_bit9     (rx_bit9),
  .frame_err   (frame_err),
  .overrun_err (overrun_err)
);

// File: tb/sim_mp_uart_rx.sv
`timescale 1ns/1ps
module sim_mp_uart_rx;
  localparam int BITCLK = 32; // 16 ticks, one tick per 2 clocks

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic       os_tick = 1'b0;
  logic       rx_en = 1'b0;
  logic       nine_bit_en = 1'b0;
  logic       addr_filt_en = 1'b0;
  logic       rx_ready = 1'b0;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       rx_bit9;
  logic       frame_err;
  logic       overrun_err;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic [7:0] last_data = 8'h00;

  always #2.5 clk = ~clk;
  always @(negedge clk) os_tick <= ~os_tick;

  mp_uart_rx u0 (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .os_tick(os_tick),
    .rx_en(rx_en), .nine_bit_en(nine_bit_en), .addr_filt_en(addr_filt_en),
    .rx_ready(rx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_bit9(rx_bit9), .frame_err(frame_err), .overrun_err(overrun_err)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: act=%0d exp<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic b9, input logic stopb);
    @(negedge clk);
    rx_line = 1'b0; idle(BITCLK);
    for (int i = 0; i < 8; i++) begin
      rx_line = d[i]; idle(BITCLK);
    end
    if (nine_bit_en) begin
      rx_line = b9; idle(BITCLK);
    end
    rx_line = stopb; idle(BITCLK);
    rx_line = 1'b1; idle(2 * BITCLK);
  endtask

  task automatic ack();
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
  endtask

  // Expect a delivery: check outputs, then read it out
  task automatic expect_deliver(input string tag, input logic [7:0] d, input logic b9, input logic fe);
    chk({tag, " valid"}, rx_valid, 1);
    chk({tag, " data"}, rx_data, d);
    chk({tag, " bit9"}, rx_bit9, b9);
    chk({tag, " ferr"}, frame_err, fe);
    ack();
    chk("R7 valid cleared after handshake", rx_valid, 0);
    last_data = d;
  endtask

  task automatic expect_drop(input string tag);
    chk({tag, " no valid"}, rx_valid, 0);
    chk({tag, " buffer kept"}, rx_data, last_data);
  endtask

  initial begin
    idle(4);
    chk("R10 reset valid", rx_valid, 0);
    chk("R10 reset ovr", overrun_err, 0);
    chk("R10 reset ferr", frame_err, 0);
    chk("R1 reset data", rx_data, 0);
    rst_n = 1'b1;
    rx_en = 1'b1;
    idle(2 * BITCLK);

    // Sweep over frame length, filter, ninth bit and data patterns
    for (int cfg = 0; cfg < 4; cfg++) begin
      nine_bit_en = cfg[0];
      addr_filt_en = cfg[1];
      for (int b = 0; b < 2; b++) begin
        for (int k = 0; k < 4; k++) begin
          logic [7:0] d;
          logic exp_b9;
          logic dlv;
          string tag;
          d = 8'((k * 8'h5B) + (cfg * 8'h11) + b + 1);
          exp_b9 = nine_bit_en & b[0];
          dlv = !(nine_bit_en && addr_filt_en) || b[0];
          if (!nine_bit_en) tag = addr_filt_en ? "R5 filter ignored" : "R1 eight-bit";
          else if (!addr_filt_en) tag = "R6 R2 pass-through";
          else tag = b[0] ? "R3 address" : "R4 data dropped";
          send(d, b[0], 1'b1);
          if (dlv) expect_deliver(tag, d, exp_b9, 1'b0);
          else     expect_drop(tag);
        end
      end
    end

    // R4: dropped data then address; address replaces it
    nine_bit_en = 1'b1; addr_filt_en = 1'b1;
    send(8'h3C, 1'b0, 1'b1);
    expect_drop("R4 drop before address");
    send(8'hA5, 1'b1, 1'b1);
    expect_deliver("R4 address after drop", 8'hA5, 1'b1, 1'b0);

    // R6: host clears the filter after being addressed
    addr_filt_en = 1'b0;
    send(8'h42, 1'b0, 1'b1);
    expect_deliver("R6 data after filter cleared", 8'h42, 1'b0, 1'b0);
    send(8'h99, 1'b1, 1'b1);
    expect_deliver("R6 address after filter cleared", 8'h99, 1'b1, 1'b0);

    // R8: framing error on a delivered frame
    send(8'h81, 1'b1, 1'b0);
    expect_deliver("R8 framing error", 8'h81, 1'b1, 1'b1);
    send(8'h18, 1'b0, 1'b1);
    expect_deliver("R8 good stop clears", 8'h18, 1'b0, 1'b0);
    addr_filt_en = 1'b1;
    send(8'h77, 1'b0, 1'b0);
    expect_drop("R8 dropped bad frame");
    chk("R8 dropped frame leaves ferr", frame_err, 0);
    addr_filt_en = 1'b0;

    // R9: overrun
    send(8'h11, 1'b0, 1'b1);
    chk("R9 first held", rx_valid, 1);
    send(8'h22, 1'b1, 1'b1);
    chk("R9 overrun set", overrun_err, 1);
    chk("R9 R7 old data kept", rx_data, 8'h11);
    chk("R7 valid held", rx_valid, 1);
    send(8'h33, 1'b0, 1'b1);
    chk("R9 halted keeps old", rx_data, 8'h11);
    chk("R9 overrun stays", overrun_err, 1);
    @(negedge clk); rx_en = 1'b0;
    idle(2);
    chk("R10 overrun cleared", overrun_err, 0);
    rx_en = 1'b1;
    expect_deliver("R9 old frame readable", 8'h11, 1'b0, 1'b0);
    send(8'h44, 1'b1, 1'b1);
    expect_deliver("R9 resumed", 8'h44, 1'b1, 1'b0);

    // R10: nothing received while disabled
    rx_en = 1'b0;
    send(8'h55, 1'b1, 1'b1);
    expect_drop("R10 disabled");
    rx_en = 1'b1;
    idle(BITCLK);

    // R11: short glitch is rejected
    @(negedge clk); rx_line = 1'b0;
    idle(8);
    rx_line = 1'b1;
    idle(12 * BITCLK);
    expect_drop("R11 glitch rejected");
    send(8'hC3, 1'b0, 1'b1);
    expect_deliver("R11 frame after glitch", 8'hC3, 1'b0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule